// File: doc/BRIEF.md
# Four-Stage Integer Pipeline with Multicycle Multiply

This block is a small in-order integer pipeline. Each instruction passes through four stages: fetch, decode with register read, execute, and write-back. It runs three-register add, subtract and multiply instructions on a file of eight 16-bit registers. Add and subtract leave execute after one cycle. A multiply stays in execute for a fixed number of cycles, three by default. While it is there, the instruction behind it waits in decode, and each held cycle sends an empty slot into write-back.

A result leaving execute is forwarded straight into the execute inputs of the next instruction in the following cycle. The register file returns a value written in the same cycle to a decode read of that register. So a stale value read early in decode is always replaced before it is used.

The program comes from an instruction memory read port, which the environment preloads. A stop instruction ends the run. When it reaches write-back, the done flag rises and both counters freeze. The cycle counter then holds the cycle of the last real write-back. A debug select reads any register for checking.

Top module: `pipe4_core`

## Requirements
- R1: While rst_ni is low: done_o is 0, retired_o is 0, cycles_o is 0 and imem_addr_o is 0. Register n holds the value n.
- R2: Instruction word bits [10:9] hold the opcode: 0 add, 1 subtract, 2 multiply, 3 stop. Bits [8:6] hold the destination, [5:3] source A and [2:0] source B. Subtract computes A minus B.
- R3: Add and subtract results wrap modulo 2^16.
- R4: Multiply writes the low 16 bits of the product and occupies execute for 3 consecutive cycles.
- R5: While a multiply is in execute, the instruction behind it stays in decode and fetch does not advance. No instruction retires in the cycle after each held cycle.
- R6: An instruction that uses the destination of the instruction just ahead of it gets the new value, with no added stall.
- R7: A decode read of a register being written back in the same cycle returns the written value.
- R8: Cycle 1 is the first cycle after reset release. cycles_o counts up by one per cycle until the stop instruction enters write-back, then holds. The sequence add R2,R1,R0; mul R4,R3,R2; sub R6,R5,R4 ends with cycles_o equal to 8.
- R9: done_o rises when the stop instruction reaches write-back and stays high. Instructions after the stop are never executed and never retired.
- R10: retired_o counts the non-stop instructions that wrote back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 8 | Instruction fetch address |
| imem_data_i | input | 11 | Instruction word at imem_addr_o, same cycle |
| dbg_sel_i | input | 3 | Register select for debug read |
| dbg_data_o | output | 16 | Contents of the selected register |
| done_o | output | 1 | The stop instruction has reached write-back |
| retired_o | output | 16 | Count of retired non-stop instructions |
| cycles_o | output | 16 | Cycle counter, frozen once done |

## Verification
The assertions assume that every program ends with a stop instruction within the preloaded memory. They also assume that imem_data_i follows imem_addr_o combinationally. The bench meets both conditions. It fills every unused memory word with the stop encoding and drives the data from an array indexed by the address. Each program starts from a fresh reset with registers at their index values, so every expected result and cycle count can be worked out by hand.

// File: rtl/pipe4_pkg.sv
package pipe4_pkg;
  localparam int OP_W = 2;
  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 2'd0,
    OP_SUB  = 2'd1,
    OP_MUL  = 2'd2,
    OP_HALT = 2'd3
  } op_e;
endpackage

// File: rtl/pipe4_regfile.sv
module pipe4_regfile #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  wa_i,
  input  logic [DATA_W-1:0] wd_i,
  input  logic [IDX_W-1:0]  ra_a_i,
  input  logic [IDX_W-1:0]  ra_b_i,
  output logic [DATA_W-1:0] rd_a_o,
  output logic [DATA_W-1:0] rd_b_o,
  input  logic [IDX_W-1:0]  dbg_sel_i,
  output logic [DATA_W-1:0] dbg_data_o
);
  logic [DATA_W-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= DATA_W'(g);
      else if (we_i && wa_i == IDX_W'(g))     regs_q[g] <= wd_i;
    end
  end

  // write-first: same-cycle write is visible to decode
  assign rd_a_o     = (we_i && wa_i == ra_a_i) ? wd_i : regs_q[ra_a_i];
  assign rd_b_o     = (we_i && wa_i == ra_b_i) ? wd_i : regs_q[ra_b_i];
  assign dbg_data_o = regs_q[dbg_sel_i];
endmodule

// File: rtl/pipe4_alu.sv
module pipe4_alu import pipe4_pkg::*; #(
  parameter int DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    if (op_i == OP_SUB) y_o = a_i - b_i;
    else                y_o = a_i + b_i;
  end
endmodule

// File: rtl/pipe4_mul.sv
module pipe4_mul #(
  parameter int DATA_W  = 16,
  parameter int MUL_LAT = 3,
  localparam int CW     = (MUL_LAT > 2) ? $clog2(MUL_LAT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] prod_o
);
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] prod_q;

  assign busy_o = valid_i && (cnt_q != CW'(MUL_LAT - 1));
  assign prod_o = prod_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      prod_q <= '0;
    end else begin
      // operands are captured in the first cycle while forwarding is live
      if (valid_i && cnt_q == '0) prod_q <= DATA_W'(a_i * b_i);
      if (busy_o) cnt_q <= cnt_q + 1'b1;
      else        cnt_q <= '0;
    end
  end
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core import pipe4_pkg::*; #(
  parameter int DATA_W   = 16,
  parameter int NREG     = 8,
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 16,
  parameter int MUL_LAT  = 3,
  localparam int RIDX_W  = $clog2(NREG),
  localparam int INSTR_W = OP_W + 3 * RIDX_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  imem_addr_o,
  input  logic [INSTR_W-1:0] imem_data_i,
  input  logic [RIDX_W-1:0]  dbg_sel_i,
  output logic [DATA_W-1:0]  dbg_data_o,
  output logic               done_o,
  output logic [CNT_W-1:0]   retired_o,
  output logic [CNT_W-1:0]   cycles_o
);
  // fetch / decode
  logic [ADDR_W-1:0]  pc_q;
  logic               id_valid_q, fetch_stop_q;
  logic [INSTR_W-1:0] id_instr_q;
  op_e                id_op;
  logic [RIDX_W-1:0]  id_rd, id_ra, id_rb;
  logic [DATA_W-1:0]  rf_a, rf_b;
  logic               fetch_is_halt;

  // execute
  logic               ex_valid_q;
  op_e                ex_op_q;
  logic [RIDX_W-1:0]  ex_rd_q, ex_ra_q, ex_rb_q;
  logic [DATA_W-1:0]  ex_a_q, ex_b_q, opnd_a, opnd_b, alu_y, mul_p, ex_res;
  logic               ex_is_mul, ex_busy;

  // write-back
  logic               wb_valid_q;
  op_e                wb_op_q;
  logic [RIDX_W-1:0]  wb_rd_q;
  logic [DATA_W-1:0]  wb_res_q;
  logic               wb_we;

  logic               done_q;
  logic [CNT_W-1:0]   retired_q, cycles_q;

  assign id_op  = op_e'(id_instr_q[INSTR_W-1 -: OP_W]);
  assign id_rd  = id_instr_q[3*RIDX_W-1 -: RIDX_W];
  assign id_ra  = id_instr_q[2*RIDX_W-1 -: RIDX_W];
  assign id_rb  = id_instr_q[RIDX_W-1:0];
  assign fetch_is_halt = op_e'(imem_data_i[INSTR_W-1 -: OP_W]) == OP_HALT;

  assign wb_we  = wb_valid_q && (wb_op_q != OP_HALT);

  pipe4_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .we_i      (wb_we),
    .wa_i      (wb_rd_q),
    .wd_i      (wb_res_q),
    .ra_a_i    (id_ra),
    .ra_b_i    (id_rb),
    .rd_a_o    (rf_a),
    .rd_b_o    (rf_b),
    .dbg_sel_i (dbg_sel_i),
    .dbg_data_o(dbg_data_o)
  );

  // execute-to-execute forwarding from the write-back register
  assign opnd_a = (wb_we && wb_rd_q == ex_ra_q) ? wb_res_q : ex_a_q;
  assign opnd_b = (wb_we && wb_rd_q == ex_rb_q) ? wb_res_q : ex_b_q;

  pipe4_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i(ex_op_q), .a_i(opnd_a), .b_i(opnd_b), .y_o(alu_y)
  );

  assign ex_is_mul = ex_valid_q && (ex_op_q == OP_MUL);

  pipe4_mul #(.DATA_W(DATA_W), .MUL_LAT(MUL_LAT)) u_mul (
    .clk_i, .rst_ni,
    .valid_i(ex_is_mul),
    .a_i    (opnd_a),
    .b_i    (opnd_b),
    .busy_o (ex_busy),
    .prod_o (mul_p)
  );

  assign ex_res = (ex_op_q == OP_MUL) ? mul_p : alu_y;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q         <= '0;
      id_valid_q   <= 1'b0;
      id_instr_q   <= '0;
      fetch_stop_q <= 1'b0;
      ex_valid_q   <= 1'b0;
      ex_op_q      <= OP_ADD;
      ex_rd_q      <= '0;
      ex_ra_q      <= '0;
      ex_rb_q      <= '0;
      ex_a_q       <= '0;
      ex_b_q       <= '0;
      wb_valid_q   <= 1'b0;
      wb_op_q      <= OP_ADD;
      wb_rd_q      <= '0;
      wb_res_q     <= '0;
    end else begin
      // write-back: bubble while execute is held
      wb_valid_q <= ex_valid_q && !ex_busy;
      wb_op_q    <= ex_op_q;
      wb_rd_q    <= ex_rd_q;
      wb_res_q   <= ex_res;
      if (!ex_busy) begin
        ex_valid_q <= id_valid_q;
        ex_op_q    <= id_op;
        ex_rd_q    <= id_rd;
        ex_ra_q    <= id_ra;
        ex_rb_q    <= id_rb;
        ex_a_q     <= rf_a;
        ex_b_q     <= rf_b;
        if (fetch_stop_q) begin
          id_valid_q <= 1'b0;
        end else begin
          id_valid_q <= 1'b1;
          id_instr_q <= imem_data_i;
          pc_q       <= pc_q + 1'b1;
          if (fetch_is_halt) fetch_stop_q <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q    <= 1'b0;
      retired_q <= '0;
      cycles_q  <= '0;
    end else begin
      if (!done_q) cycles_q <= cycles_q + 1'b1;
      if (ex_valid_q && !ex_busy && ex_op_q == OP_HALT) done_q <= 1'b1;
      if (wb_we) retired_q <= retired_q + 1'b1;
    end
  end

  assign imem_addr_o = pc_q;
  assign done_o      = done_q;
  assign retired_o   = retired_q;
  assign cycles_o    = cycles_q;
endmodule

// File: rtl/pipe4_core_chk.sv
module pipe4_core_chk #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] imem_addr_i,
  input logic              done_i,
  input logic [CNT_W-1:0]  retired_i,
  input logic [CNT_W-1:0]  cycles_i,
  input logic              ex_busy_i
);
  AST_CYCLES_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> cycles_i == CNT_W'($past(cycles_i) + 1'b1)); // R8

  AST_DONE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_i && $stable(cycles_i) && $stable(retired_i)); // R9

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_busy_i |=> $stable(imem_addr_i)); // R5

  AST_STALL_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ex_busy_i |=> ##1 $stable(retired_i)); // R5

  AST_RETIRE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (retired_i == $past(retired_i)) ||
             (retired_i == CNT_W'($past(retired_i) + 1'b1))); // R10
endmodule

bind pipe4_core pipe4_core_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .imem_addr_i(imem_addr_o),
  .done_i     (done_o),
  .retired_i  (retired_o),
  .cycles_i   (cycles_o),
  .ex_busy_i  (ex_busy)
);

// File: tb/pipe4_core_tb_top.sv
module pipe4_core_tb_top;
  localparam int CLK_P = 10;
  localparam logic [1:0] ADD = 2'd0, SUB = 2'd1, MUL = 2'd2, HLT = 2'd3;
  localparam logic [10:0] HALT_W = {HLT, 9'd0};

  typedef struct packed {
    logic [10:0] i0, i1, i2;
    logic [2:0]  reg_sel;
    logic [15:0] val;
    logic [15:0] cyc;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VEC [NVEC] = '{
    // R8 R4: canonical sequence, R6 = 5 - 3*(1+0)
    '{{ADD,3'd2,3'd1,3'd0}, {MUL,3'd4,3'd3,3'd2}, {SUB,3'd6,3'd5,3'd4}, 3'd6, 16'd2,      16'd8},
    // R6: back-to-back forwarding, 14 -> 28 -> 28-6
    '{{ADD,3'd1,3'd7,3'd7}, {ADD,3'd1,3'd1,3'd1}, {SUB,3'd2,3'd1,3'd6}, 3'd2, 16'd22,     16'd6},
    // R3: subtract wraps to 0xFFFF, add wraps to 0xFFFE
    '{{SUB,3'd0,3'd0,3'd1}, {ADD,3'd3,3'd0,3'd0}, {ADD,3'd4,3'd4,3'd4}, 3'd3, 16'hFFFE,   16'd6},
    // R4: chained multiplies, 49 -> 2401 -> low 16 of 2401^2
    '{{MUL,3'd1,3'd7,3'd7}, {MUL,3'd1,3'd1,3'd1}, {MUL,3'd1,3'd1,3'd1}, 3'd1, 16'd63169,  16'd12},
    // R7: decode reads R1 in the cycle it is written back
    '{{ADD,3'd1,3'd2,3'd3}, {SUB,3'd0,3'd7,3'd7}, {ADD,3'd2,3'd1,3'd1}, 3'd2, 16'd10,     16'd6}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  imem_addr;
  logic [10:0] imem_data;
  logic [2:0]  dbg_sel = '0;
  logic [15:0] dbg_data;
  logic        done;
  logic [15:0] retired, cycles;
  logic [10:0] mem [16];

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  assign imem_data = mem[imem_addr[3:0]];

  pipe4_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dbg_sel_i(dbg_sel), .dbg_data_o(dbg_data),
    .done_o(done), .retired_o(retired), .cycles_o(cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_reg(input logic [2:0] r);
    dbg_sel = r;
    return 16'(0);
  endfunction

  task automatic reg_check(input string req, input logic [2:0] r, input logic [15:0] exp);
    dbg_sel = r;
    #1;
    check(req, {16'd0, dbg_data}, {16'd0, exp});
  endtask

  task automatic load(input logic [10:0] a, input logic [10:0] b, input logic [10:0] c);
    for (int k = 0; k < 16; k++) mem[k] = HALT_W;
    mem[0] = a; mem[1] = b; mem[2] = c;
  endtask

  task automatic start();
    @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_done(input string req);
    for (int k = 0; k < 200 && !done; k++) @(negedge clk);
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s: actual done=0 expected done=1", req);
    end
  endtask

  initial begin
    #(CLK_P * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    load(HALT_W, HALT_W, HALT_W);
    repeat (2) @(negedge clk);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 retired", {16'd0, retired}, 32'd0);
    check("R1 cycles", {16'd0, cycles}, 32'd0);
    check("R1 addr", {24'd0, imem_addr}, 32'd0);
    reg_check("R1 reg5", 3'd5, 16'd5);
    reg_check("R1 reg0", 3'd0, 16'd0);

    // vector table (R2 encoding in every entry)
    for (int v = 0; v < NVEC; v++) begin
      load(VEC[v].i0, VEC[v].i1, VEC[v].i2);
      start();
      wait_done("R9 vec");
      repeat (3) @(negedge clk);
      check($sformatf("R8 vec%0d cycles", v), {16'd0, cycles}, {16'd0, VEC[v].cyc});
      check($sformatf("R10 vec%0d retired", v), {16'd0, retired}, 32'd3);
      check($sformatf("R9 vec%0d done held", v), {31'd0, done}, 32'd1);
      reg_check($sformatf("R2 vec%0d result", v), VEC[v].reg_sel, VEC[v].val);
    end

    // R9: instruction after stop never executes
    load({ADD,3'd1,3'd1,3'd1}, HALT_W, {ADD,3'd2,3'd7,3'd7});
    start();
    wait_done("R9 stop");
    repeat (5) @(negedge clk);
    check("R9 cycles frozen", {16'd0, cycles}, 32'd4);
    check("R10 one retired", {16'd0, retired}, 32'd1);
    reg_check("R9 R2 untouched", 3'd2, 16'd2);
    reg_check("R3 R1 doubled", 3'd1, 16'd2);

    // R5: independent add behind a multiply waits in decode
    load({MUL,3'd1,3'd2,3'd3}, {ADD,3'd4,3'd5,3'd5}, HALT_W);
    start();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R5 no retire after 4", {16'd0, retired}, 32'd0);
    check("R5 fetch held", {24'd0, imem_addr}, 32'd2);
    @(negedge clk);
    check("R5 no retire after 5", {16'd0, retired}, 32'd0);
    @(negedge clk);
    check("R4 mul retired after 6", {16'd0, retired}, 32'd1);
    @(negedge clk);
    check("R5 add retired after 7", {16'd0, retired}, 32'd2);
    wait_done("R5 stop");
    repeat (2) @(negedge clk);
    check("R5 cycles", {16'd0, cycles}, 32'd7);
    reg_check("R4 product", 3'd1, 16'd6);
    reg_check("R5 add result", 3'd4, 16'd10);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  logic [15:0] unused_rd;
  initial unused_rd = rd_reg(3'd0);
endmodule